// File: doc/BRIEF.md
# Receive Frame Screening Filter

This block sits after the receive header parser and before the buffer writer. For every frame it takes the parsed facts (IP version, source and destination addresses, transport type, fragment status) and the error flags raised by the link, network and transport checkers. From these it makes one accept-or-drop decision. A registered decision and a reason code appear exactly one clock after the frame strobe, so the downstream writer can discard the frame before it commits any buffer space.

Two kinds of screening are combined. The error screen drops frames whose checkers flagged a problem, with one enable per layer. It can also discard every IP fragment. The address screen is off after reset. It rejects spoofed or nonsensical traffic: identical source and destination, loopback or unspecified addresses, non-unicast sources, and TCP to or from group addresses. Five enable bits are held in a small configuration register. Reset loads a safe default into it, and a one-cycle write strobe replaces it.

Top module: `rx_frame_screen`

## Requirements
- R1: `out_vld` is high in the cycle after each cycle with `in_vld` high, and low otherwise. `out_drop` is never high without `out_vld`. Back-to-back frames each get their own decision.
- R2: After reset the enables are: link-error drop on; network-error drop, transport-error drop, fragment drop and address screen off. A cycle with `cfg_we` high loads `cfg_wdata` with bit 0 link, bit 1 network, bit 2 transport, bit 3 fragment, bit 4 address screen. The new value applies from the next cycle.
- R3: With bit 0 set, a frame with `in_l2_err` is dropped with reason 1.
- R4: With bit 1 set, a frame is dropped with reason 2 if `in_l3_hdr_err` is set. It is also dropped with reason 2 if `in_l3_csum_err` is set and the frame is TCP or UDP. A checksum error on any other transport is ignored.
- R5: With bit 2 set, a frame with `in_l4_err` is dropped with reason 3.
- R6: With bit 3 set, every frame with `in_is_frag` is dropped with reason 4, even if it has no errors.
- R7: With bit 4 set, a frame whose source equals its destination is dropped with reason 5. For IPv4 only the low 32 address bits are compared; for IPv6 all 128 are.
- R8: With bit 4 set, an IPv4 frame is dropped with reason 6 if either address is in 127.0.0.0/8. A TCP IPv4 frame is also dropped with reason 6 if either address is multicast (224.0.0.0/4) or 255.255.255.255.
- R9: With bit 4 set, an IPv6 frame is dropped with reason 6 if the source is in ff00::/8, or if either address is ::1 or ::. A TCP IPv6 frame is also dropped with reason 6 if the destination is in ff00::/8.
- R10: When several causes apply, the reason is the first match in this order: link (1), network (2), transport (3), fragment (4), equal addresses (5), address class (6). A cause whose enable is clear has no effect. An accepted frame has `out_drop` low and reason 0, and the reason is 0 whenever `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the enable register |
| cfg_wdata | input | 5 | Enable bits {addr screen, fragment, transport, network, link} |
| in_vld | input | 1 | Parsed frame facts valid this cycle |
| in_is_v6 | input | 1 | 1 for IPv6, 0 for IPv4 |
| in_src | input | 128 | Source address (IPv4 in bits 31:0) |
| in_dst | input | 128 | Destination address (IPv4 in bits 31:0) |
| in_is_tcp | input | 1 | Transport is TCP |
| in_is_udp | input | 1 | Transport is UDP |
| in_is_frag | input | 1 | Frame is an IP fragment |
| in_l2_err | input | 1 | Link length or CRC error |
| in_l3_hdr_err | input | 1 | IP version or length error |
| in_l3_csum_err | input | 1 | IP header checksum error |
| in_l4_err | input | 1 | Transport length, checksum or other error |
| out_vld | output | 1 | Decision valid |
| out_drop | output | 1 | Drop the frame |
| out_reason | output | 3 | Reason code, 0 when accepted |

## Verification
A wrong enable register state shows at the ports on the first frame after reset or after a load. A frame with the affected error then gets the opposite verdict one cycle after its strobe, so every test starts with the default enables. A misclassified address or a swapped priority shows as a wrong reason code in the same single cycle. The vectors therefore pair each address rule with a near miss: the same address with UDP instead of TCP, or a multicast source against a multicast destination. They also stack several causes in one frame to expose the priority order.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W = 128;
  localparam int V4_W   = 32;
  localparam int RSN_W  = 3;
  localparam int CFG_W  = 5;

  typedef enum logic [RSN_W-1:0] {
    RSN_PASS  = 3'd0,
    RSN_LINK  = 3'd1,
    RSN_NET   = 3'd2,
    RSN_XPORT = 3'd3,
    RSN_FRAG  = 3'd4,
    RSN_SAME  = 3'd5,
    RSN_CLASS = 3'd6
  } reason_e;

  typedef struct packed {
    logic addr_en;
    logic frag_en;
    logic xport_en;
    logic net_en;
    logic link_en;
  } cfg_t;
endpackage

// File: rtl/rxf_cfg_reg.sv
module rxf_cfg_reg
  import rxf_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 5'b00001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= cfg_t'(RESET_VAL);
    else if (we) q <= cfg_t'(wdata);
  end
endmodule

// File: rtl/rxf_v4_class.sv
module rxf_v4_class #(
  parameter int W = 32
) (
  input  logic [W-1:0] addr,
  output logic         is_loop,
  output logic         is_group
);
  localparam logic [7:0] LOOP_NET  = 8'd127;
  localparam logic [3:0] GROUP_NIB = 4'hE;

  logic is_mcast;
  logic is_bcast;

  always_comb begin
    is_loop  = (addr[W-1 -: 8] == LOOP_NET);
    is_mcast = (addr[W-1 -: 4] == GROUP_NIB);
    is_bcast = &addr;
    is_group = is_mcast | is_bcast;
  end
endmodule

// File: rtl/rxf_v6_class.sv
module rxf_v6_class #(
  parameter int W = 128
) (
  input  logic [W-1:0] addr,
  output logic         is_loop,
  output logic         is_unspec,
  output logic         is_group
);
  always_comb begin
    is_loop   = (addr == W'(1));
    is_unspec = (addr == '0);
    is_group  = &addr[W-1 -: 8];
  end
endmodule

// File: rtl/rx_frame_screen.sv
module rx_frame_screen
  import rxf_pkg::*;
#(
  parameter int               AW      = ADDR_W,
  parameter int               V4W     = V4_W,
  parameter logic [CFG_W-1:0] CFG_DEF = 5'b00001
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_vld,
  input  logic             in_is_v6,
  input  logic [AW-1:0]    in_src,
  input  logic [AW-1:0]    in_dst,
  input  logic             in_is_tcp,
  input  logic             in_is_udp,
  input  logic             in_is_frag,
  input  logic             in_l2_err,
  input  logic             in_l3_hdr_err,
  input  logic             in_l3_csum_err,
  input  logic             in_l4_err,
  output logic             out_vld,
  output logic             out_drop,
  output logic [RSN_W-1:0] out_reason
);
  localparam int NSIDE = 2;  // index 0 = source, 1 = destination

  cfg_t cfg_q;

  rxf_cfg_reg #(.RESET_VAL(CFG_DEF)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  logic [AW-1:0] side_addr [NSIDE];
  logic [NSIDE-1:0] v4_loop, v4_group;
  logic [NSIDE-1:0] v6_loop, v6_unspec, v6_group;

  assign side_addr[0] = in_src;
  assign side_addr[1] = in_dst;

  for (genvar k = 0; k < NSIDE; k++) begin : g_side
    rxf_v4_class #(.W(V4W)) u_v4 (
      .addr     (side_addr[k][V4W-1:0]),
      .is_loop  (v4_loop[k]),
      .is_group (v4_group[k])
    );
    rxf_v6_class #(.W(AW)) u_v6 (
      .addr      (side_addr[k]),
      .is_loop   (v6_loop[k]),
      .is_unspec (v6_unspec[k]),
      .is_group  (v6_group[k])
    );
  end

  logic    same_addr, bad_v4, bad_v6, bad_class;
  logic    hit_link, hit_net, hit_xport, hit_frag, hit_same, hit_class;
  reason_e rsn_d;

  always_comb begin
    same_addr = in_is_v6 ? (in_src == in_dst)
                         : (in_src[V4W-1:0] == in_dst[V4W-1:0]);
    bad_v4    = (|v4_loop) | (in_is_tcp & (|v4_group));
    bad_v6    = v6_group[0] | (|v6_loop) | (|v6_unspec) |
                (in_is_tcp & v6_group[1]);
    bad_class = in_is_v6 ? bad_v6 : bad_v4;

    hit_link  = cfg_q.link_en  & in_l2_err;
    hit_net   = cfg_q.net_en   & (in_l3_hdr_err |
                                  (in_l3_csum_err & (in_is_tcp | in_is_udp)));
    hit_xport = cfg_q.xport_en & in_l4_err;
    hit_frag  = cfg_q.frag_en  & in_is_frag;
    hit_same  = cfg_q.addr_en  & same_addr;
    hit_class = cfg_q.addr_en  & bad_class;

    if      (hit_link)  rsn_d = RSN_LINK;
    else if (hit_net)   rsn_d = RSN_NET;
    else if (hit_xport) rsn_d = RSN_XPORT;
    else if (hit_frag)  rsn_d = RSN_FRAG;
    else if (hit_same)  rsn_d = RSN_SAME;
    else if (hit_class) rsn_d = RSN_CLASS;
    else                rsn_d = RSN_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld    <= 1'b0;
      out_drop   <= 1'b0;
      out_reason <= RSN_PASS;
    end else begin
      out_vld    <= in_vld;
      out_drop   <= in_vld & (rsn_d != RSN_PASS);
      out_reason <= in_vld ? rsn_d : RSN_PASS;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
  import rxf_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic             in_l2_err,
  input logic             in_is_frag,
  input cfg_t             cfg_q,
  input logic             out_vld,
  input logic             out_drop,
  input logic [RSN_W-1:0] out_reason
);
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);  // R1
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);  // R1
  AST_DROP_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
    out_drop |-> out_vld);  // R1
  AST_LINK_ERR_WINS: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_l2_err && cfg_q.link_en) |=> (out_drop && out_reason == 3'd1));  // R3
  AST_FRAG_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_is_frag && cfg_q.frag_en) |=> out_drop);  // R6
  AST_REASON_AGREES: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_drop == (out_reason != 3'd0)));  // R10
  AST_IDLE_REASON_ZERO: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_reason == 3'd0));  // R10
endmodule

bind rx_frame_screen rxf_checker u_rxf_checker (
  .clk        (clk),
  .rst        (rst),
  .in_vld     (in_vld),
  .in_l2_err  (in_l2_err),
  .in_is_frag (in_is_frag),
  .cfg_q      (cfg_q),
  .out_vld    (out_vld),
  .out_drop   (out_drop),
  .out_reason (out_reason)
);

// File: tb/rx_frame_screen_tb.sv
module rx_frame_screen_tb;
  typedef struct packed {
    logic [4:0]   cfg;
    logic         v6, tcp, udp, frag, l2, l3h, l3c, l4;
    logic [127:0] src, dst;
    logic         drop;
    logic [2:0]   rsn;
    logic [3:0]   req;
  } vec_t;

  localparam logic [127:0] A_V4_1 = 128'h0A00_0001;
  localparam logic [127:0] A_V4_2 = 128'h0A00_0002;
  localparam logic [127:0] A_V4_LO = 128'h7F00_0005;
  localparam logic [127:0] A_V4_MC = 128'hE001_0203;
  localparam logic [127:0] A_V4_BC = 128'hFFFF_FFFF;
  localparam logic [127:0] A_V4_HI = 128'hDEAD_0000_0000_0000_0000_0000_0A00_0001;
  localparam logic [127:0] A_V6_U1 = 128'h2001_0000_0000_0000_0000_0000_0000_0001;
  localparam logic [127:0] A_V6_U5 = 128'h2001_0000_0000_0000_0000_0000_0000_0005;
  localparam logic [127:0] A_V6_MC = 128'hFF02_0000_0000_0000_0000_0000_0000_0001;
  localparam logic [127:0] A_V6_LO = 128'h1;
  localparam logic [127:0] A_V6_UN = 128'h0;

  localparam int NV = 24;
  // cfg, v6, tcp, udp, frag, l2, l3h, l3c, l4, src, dst, drop, reason, req
  localparam vec_t VECS [NV] = '{
    '{5'b11111, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_1, A_V4_2, 1'b0, 3'd0, 4'd10}, // R10 clean
    '{5'b00001, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, A_V4_1, A_V4_2, 1'b1, 3'd1, 4'd3},  // R3
    '{5'b00000, 1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, A_V4_1, A_V4_2, 1'b0, 3'd0, 4'd10}, // R10 disabled
    '{5'b00010, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0, A_V4_1, A_V4_2, 1'b0, 3'd0, 4'd4},  // R4 csum non tcp/udp
    '{5'b00010, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0, A_V4_1, A_V4_2, 1'b1, 3'd2, 4'd4},  // R4 csum udp
    '{5'b00010, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, A_V4_1, A_V4_2, 1'b1, 3'd2, 4'd4},  // R4 hdr
    '{5'b00100, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1, A_V4_1, A_V4_2, 1'b1, 3'd3, 4'd5},  // R5
    '{5'b01000, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, A_V4_1, A_V4_2, 1'b1, 3'd4, 4'd6},  // R6
    '{5'b00000, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, A_V4_1, A_V4_2, 1'b0, 3'd0, 4'd6},  // R6 off
    '{5'b10000, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_1, A_V4_1, 1'b1, 3'd5, 4'd7},  // R7 v4
    '{5'b10000, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_HI,A_V4_1, 1'b1, 3'd5, 4'd7},  // R7 low 32 only
    '{5'b10000, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_LO,A_V4_1, 1'b1, 3'd6, 4'd8},  // R8 loopback
    '{5'b10000, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_1, A_V4_MC,1'b1, 3'd6, 4'd8},  // R8 tcp mcast
    '{5'b10000, 1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_1, A_V4_MC,1'b0, 3'd0, 4'd8},  // R8 udp mcast ok
    '{5'b10000, 1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V4_BC,A_V4_1, 1'b1, 3'd6, 4'd8},  // R8 tcp bcast
    '{5'b10000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_MC,A_V6_U1,1'b1, 3'd6, 4'd9},  // R9 mcast src
    '{5'b10000, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_U1,A_V6_MC,1'b1, 3'd6, 4'd9},  // R9 tcp mcast dst
    '{5'b10000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_U1,A_V6_MC,1'b0, 3'd0, 4'd9},  // R9 udp mcast dst ok
    '{5'b10000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_U1,A_V6_LO,1'b1, 3'd6, 4'd9},  // R9 ::1
    '{5'b10000, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_UN,A_V6_U1,1'b1, 3'd6, 4'd9},  // R9 ::
    '{5'b10000, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_U5,A_V6_U5,1'b1, 3'd5, 4'd7},  // R7 v6
    '{5'b01111, 1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0, A_V6_U5,A_V6_U5,1'b0, 3'd0, 4'd10}, // R10 addr off
    '{5'b11111, 1'b0,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1, A_V4_LO,A_V4_LO,1'b1, 3'd1, 4'd10}, // R10 link first
    '{5'b11110, 1'b0,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1, A_V4_LO,A_V4_LO,1'b1, 3'd2, 4'd10}  // R10 net next
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_wdata = '0;
  logic         in_vld = 1'b0, in_is_v6 = 1'b0, in_is_tcp = 1'b0, in_is_udp = 1'b0;
  logic         in_is_frag = 1'b0, in_l2_err = 1'b0, in_l3_hdr_err = 1'b0;
  logic         in_l3_csum_err = 1'b0, in_l4_err = 1'b0;
  logic [127:0] in_src = '0, in_dst = '0;
  logic         out_vld, out_drop;
  logic [2:0]   out_reason;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_frame_screen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_vld(in_vld), .in_is_v6(in_is_v6), .in_src(in_src), .in_dst(in_dst),
    .in_is_tcp(in_is_tcp), .in_is_udp(in_is_udp), .in_is_frag(in_is_frag),
    .in_l2_err(in_l2_err), .in_l3_hdr_err(in_l3_hdr_err),
    .in_l3_csum_err(in_l3_csum_err), .in_l4_err(in_l4_err),
    .out_vld(out_vld), .out_drop(out_drop), .out_reason(out_reason)
  );

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got vld/drop/reason=%b expected %b", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [4:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one frame at a negedge; the result is registered on the next posedge
  task automatic drive(input vec_t v);
    @(negedge clk);
    in_vld = 1'b1; in_is_v6 = v.v6; in_is_tcp = v.tcp; in_is_udp = v.udp;
    in_is_frag = v.frag; in_l2_err = v.l2; in_l3_hdr_err = v.l3h;
    in_l3_csum_err = v.l3c; in_l4_err = v.l4; in_src = v.src; in_dst = v.dst;
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0; in_l2_err = 1'b0; in_l3_hdr_err = 1'b0; in_l3_csum_err = 1'b0;
    in_l4_err = 1'b0; in_is_frag = 1'b0;
  endtask

  function automatic vec_t mk(input logic l2, input logic l3h, input logic [127:0] s,
                              input logic [127:0] d);
    vec_t v = '0;
    v.udp = 1'b1; v.l2 = l2; v.l3h = l3h; v.src = s; v.dst = d;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {out_vld, out_drop, out_reason}, 5'b00000);
    rst = 1'b0;

    // R2 defaults: link error drops, network error and equal addresses pass
    drive(mk(1'b1, 1'b0, A_V4_1, A_V4_2));
    idle();
    check("R2 default link drop", {out_vld, out_drop, out_reason}, 5'b11001);
    drive(mk(1'b0, 1'b1, A_V4_1, A_V4_1));
    idle();
    check("R2 default net/addr off", {out_vld, out_drop, out_reason}, 5'b10000);
    @(negedge clk);
    check("R1 out_vld falls", {out_vld, out_drop, out_reason}, 5'b00000);

    for (int i = 0; i < NV; i++) begin
      load_cfg(VECS[i].cfg);
      drive(VECS[i]);
      idle();
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {out_vld, out_drop, out_reason}, {1'b1, VECS[i].drop, VECS[i].rsn});
    end

    // R1 back to back: drop then accept on consecutive cycles
    load_cfg(5'b00001);
    drive(mk(1'b1, 1'b0, A_V4_1, A_V4_2));
    drive(mk(1'b0, 1'b0, A_V4_1, A_V4_2));
    check("R1 back-to-back first", {out_vld, out_drop, out_reason}, 5'b11001);
    idle();
    check("R1 back-to-back second", {out_vld, out_drop, out_reason}, 5'b10000);

    // R2 new value applies from next cycle; reset restores defaults
    load_cfg(5'b00010);
    drive(mk(1'b1, 1'b1, A_V4_1, A_V4_2));
    idle();
    check("R2 loaded cfg", {out_vld, out_drop, out_reason}, 5'b11010);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    drive(mk(1'b1, 1'b1, A_V4_1, A_V4_2));
    idle();
    check("R2 defaults after reset", {out_vld, out_drop, out_reason}, 5'b11001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule